// File: doc/BRIEF.md
# Rank Power-Mode Controller

This block follows the power mode of one memory rank and decides when that rank may drop into a low-power mode and when it must come back out. It watches four things: bank open and close events, the number of commands still scheduled for the rank, the rank's read and write queue occupancy, and the bus direction the scheduler is heading into. It also exchanges a request and completion handshake with the refresh sequencer. From these it produces:

- the current mode;
- a flag that marks the rank as low-power;
- one-cycle strobes that tell the command path when to issue power-down entry, when to issue power-down exit, and when commands may resume.

The modes are idle (all banks closed), active (at least one bank open), active power-down, precharge power-down, refresh and self-refresh. Self-refresh can only be reached by accepting a refresh while the rank sits in precharge power-down. When that refresh finishes, the rank moves on into self-refresh instead of returning to precharge power-down.

Power-down entry is scheduled a fixed number of cycles after it is requested. Newer activity can still override it before it takes effect. After entry, the rank must stay in the low-power mode for a minimum residency before an exit may start. After the exit command, a further exit delay must pass before the rank is reported awake.

Top module: `rank_pwr_ctrl`

## Requirements
- R1: After reset, `pwr_state` reads 0 (idle), and `low_pwr`, `pdn_enter`, `pdn_exit`, `wake_up` and `ref_ack` are all low. The state codes are: idle 0, active 1, active power-down 2, precharge power-down 3, refresh 4, self-refresh 5.
- R2: The block keeps a count of open banks that saturates at 0 and at NUM_BANKS. Counting applies only in idle or active while no exit is in progress. The state is active (1) in the cycle after the count becomes non-zero and idle (0) in the cycle after it returns to zero. A close event while no bank is open leaves the count at zero.
- R3: `pdn_req` is accepted only when all of the following hold: the state is idle or active, `ops_pending` is zero, no exit is in progress, and there is no bank event in the same cycle. A request that fails these conditions is ignored. On acceptance, `low_pwr` is high in the next cycle.
- R4: An accepted entry takes effect ENTRY_DLY+1 cycles after the request edge. Active goes to active power-down and idle goes to precharge power-down, and `pdn_enter` pulses for one cycle. If `ops_pending` is non-zero at that moment, the entry is dropped and `low_pwr` falls.
- R5: While an entry is still pending, a `wake_req` or any bank event cancels it and clears `low_pwr`. A further accepted `pdn_req` restarts the entry delay.
- R6: An exit from a low-power mode starts no earlier than MIN_RES+1 cycles after the edge that entered that mode. A wake request that arrives earlier is held until then.
- R7: An exit moves active power-down to active, and precharge power-down or self-refresh to idle, with a one-cycle `pdn_exit`. `wake_up` pulses EXIT_DLY+1 cycles after the exit edge. `low_pwr` stays high until that pulse and falls with it.
- R8: `ref_req` is accepted in idle (with no exit in progress) or in precharge power-down. On acceptance the state becomes refresh in the next cycle and `ref_ack` pulses. Refresh takes priority over `pdn_req`. In active, active power-down and self-refresh, `ref_req` is ignored.
- R9: On `ref_done`, a refresh that was taken from idle returns to idle. A refresh taken from precharge power-down enters self-refresh with a `pdn_enter` pulse, provided that `ops_pending` is zero and no wake request or forced exit is present. Otherwise it returns to idle with `low_pwr` cleared.
- R10: Self-refresh is left without `wake_req` when `rd_q_cnt` is non-zero. It is also left when `bus_wr_next` is 1 and `wr_q_cnt` is non-zero. Queued writes alone, while the bus is heading into reads, do not cause an exit.
- R11: Bank events are ignored in the low-power modes and during an exit delay. They change neither the state nor the open-bank count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| act_evt | input | 1 | A bank of this rank was opened |
| pre_evt | input | 1 | A bank of this rank was closed |
| ops_pending | input | OPS_W | Scheduled activate, read, write and refresh operations for the rank |
| rd_q_cnt | input | Q_W | Reads queued for the rank |
| wr_q_cnt | input | Q_W | Writes queued for the rank |
| bus_wr_next | input | 1 | 1 when the bus is heading into write mode |
| pdn_req | input | 1 | Request to enter power-down |
| wake_req | input | 1 | Request to leave power-down or cancel a pending entry |
| ref_req | input | 1 | Refresh sequencer asks to start a refresh |
| ref_done | input | 1 | Refresh sequencer reports completion |
| pwr_state | output | 3 | Current mode code |
| low_pwr | output | 1 | Low-power flag, from entry request until exit completes |
| pdn_enter | output | 1 | One-cycle strobe when a low-power mode is entered |
| pdn_exit | output | 1 | One-cycle strobe when an exit begins |
| wake_up | output | 1 | One-cycle strobe when commands may issue again |
| ref_ack | output | 1 | One-cycle strobe when a refresh is accepted |

## Verification
Every output of this block is a register, so each result appears one edge after the cycle that decides it. The timed results fall due as follows:

- an accepted power-down request shows in `low_pwr` one cycle later;
- entry lands ENTRY_DLY+1 edges after the request;
- the earliest exit lands MIN_RES+1 edges after entry;
- `wake_up` lands EXIT_DLY+1 edges after `pdn_exit`.

The bench drives its inputs and samples the outputs one nanosecond after a rising edge. It either steps an exact number of edges before comparing, or counts the edges until a strobe appears and compares that count with the figure above. Ignored stimulus is confirmed by reading the state both right after it and again after a later event that would expose a changed bank count.

// File: rtl/rank_pwr_pkg.sv
`timescale 1ns/1ps
package rank_pwr_pkg;

   typedef enum logic [2:0] {
      PS_IDLE    = 3'd0,
      PS_ACT     = 3'd1,
      PS_ACT_PDN = 3'd2,
      PS_PRE_PDN = 3'd3,
      PS_REF     = 3'd4,
      PS_SREF    = 3'd5
   } pwr_state_e;

   function automatic logic is_low_pwr(input pwr_state_e s);
      return (s == PS_ACT_PDN) || (s == PS_PRE_PDN) || (s == PS_SREF);
   endfunction

endpackage

// File: rtl/rank_down_counter.sv
`timescale 1ns/1ps
module rank_down_counter #(
   parameter int unsigned MAX = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic run,
   output logic zero
);
   localparam int unsigned W = (MAX < 1) ? 1 : $clog2(MAX + 1);

   generate
      if (MAX == 0) begin : g_const
         // no delay configured: always expired
         assign zero = 1'b1;
      end else begin : g_cnt
         localparam logic [W-1:0] LOADV = W'(MAX);
         logic [W-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      cnt_q <= '0;
            else if (load)                   cnt_q <= LOADV;
            else if (run && (cnt_q != '0))   cnt_q <= cnt_q - 1'b1;
         end

         assign zero = (cnt_q == '0);

         // R6
         cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= LOADV);
      end
   endgenerate
endmodule

// File: rtl/rank_bank_tracker.sv
`timescale 1ns/1ps
module rank_bank_tracker #(
   parameter int unsigned NUM_BANKS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic act_evt,
   input  logic pre_evt,
   output logic any_open_nxt
);
   localparam int unsigned CW = $clog2(NUM_BANKS + 1);
   localparam logic [CW-1:0] FULL = CW'(NUM_BANKS);

   logic [CW-1:0] cnt_q, cnt_d;

   always_comb begin
      cnt_d = cnt_q;
      if (en) begin
         unique case ({act_evt, pre_evt})
            2'b10:   if (cnt_q != FULL) cnt_d = cnt_q + 1'b1;
            2'b01:   if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
            default: cnt_d = cnt_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign any_open_nxt = (cnt_d != '0);

   // R2
   open_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= FULL);

   // R11
   frozen_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(cnt_q));
endmodule

// File: rtl/rank_pwr_fsm.sv
`timescale 1ns/1ps
module rank_pwr_fsm
   import rank_pwr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       act_evt,
   input  logic       pre_evt,
   input  logic       bank_open_nxt,
   input  logic       ops_idle,
   input  logic       pdn_req,
   input  logic       wake_req,
   input  logic       ref_req,
   input  logic       ref_done,
   input  logic       force_exit,
   input  logic       entry_zero,
   input  logic       res_zero,
   input  logic       exit_zero,
   output pwr_state_e state_o,
   output logic       low_pwr_o,
   output logic       pdn_enter_o,
   output logic       pdn_exit_o,
   output logic       wake_up_o,
   output logic       ref_ack_o,
   output logic       bank_en_o,
   output logic       entry_load_o,
   output logic       entry_run_o,
   output logic       res_load_o,
   output logic       res_run_o,
   output logic       exit_load_o,
   output logic       exit_run_o
);
   pwr_state_e state_q, n_state;
   logic pend_q, n_pend;
   logic lp_q, n_lp;
   logic exiting_q, n_exiting;
   logic wake_q, n_wake;
   logic prior_q, n_prior;
   logic enter_q, n_enter;
   logic exit_q, n_exit;
   logic wup_q, n_wup;
   logic ack_q, n_ack;
   logic bank_ev, wake_any;

   always_comb begin
      n_state = state_q;  n_pend = pend_q;   n_lp = lp_q;
      n_exiting = exiting_q; n_wake = wake_q; n_prior = prior_q;
      n_enter = 1'b0; n_exit = 1'b0; n_wup = 1'b0; n_ack = 1'b0;
      entry_load_o = 1'b0; res_load_o = 1'b0; exit_load_o = 1'b0;
      bank_en_o = 1'b0;
      bank_ev  = act_evt | pre_evt;
      wake_any = wake_req | wake_q | ((state_q == PS_SREF) & force_exit);
      unique case (state_q)
         PS_IDLE, PS_ACT: begin
            if (exiting_q) begin
               if (exit_zero) begin
                  n_exiting = 1'b0; n_lp = 1'b0; n_wup = 1'b1;
               end
            end else if (ref_req && (state_q == PS_IDLE)) begin
               n_state = PS_REF; n_ack = 1'b1; n_prior = 1'b0;
               n_pend = 1'b0; n_lp = 1'b0; n_wake = 1'b0;
            end else begin
               bank_en_o = 1'b1;
               if (bank_ev) n_state = bank_open_nxt ? PS_ACT : PS_IDLE;
               if (pend_q) begin
                  if (wake_req || bank_ev) begin
                     n_pend = 1'b0; n_lp = 1'b0;
                  end else if (pdn_req && ops_idle) begin
                     entry_load_o = 1'b1;
                  end else if (entry_zero) begin
                     n_pend = 1'b0;
                     if (ops_idle) begin
                        n_state = (state_q == PS_ACT) ? PS_ACT_PDN : PS_PRE_PDN;
                        n_enter = 1'b1; res_load_o = 1'b1;
                     end else begin
                        n_lp = 1'b0;
                     end
                  end
               end else if (pdn_req && ops_idle && !bank_ev) begin
                  n_pend = 1'b1; n_lp = 1'b1; entry_load_o = 1'b1;
               end
            end
         end
         PS_ACT_PDN, PS_PRE_PDN, PS_SREF: begin
            if ((state_q == PS_PRE_PDN) && ref_req) begin
               n_state = PS_REF; n_ack = 1'b1; n_prior = 1'b1;
            end else if (wake_any) begin
               if (res_zero) begin
                  n_state = (state_q == PS_ACT_PDN) ? PS_ACT : PS_IDLE;
                  n_exit = 1'b1; n_exiting = 1'b1; exit_load_o = 1'b1;
                  n_wake = 1'b0;
               end else begin
                  n_wake = 1'b1;
               end
            end
         end
         PS_REF: begin
            if (ref_done) begin
               if (prior_q && ops_idle && !wake_q && !wake_req && !force_exit) begin
                  n_state = PS_SREF; n_enter = 1'b1; res_load_o = 1'b1;
               end else begin
                  n_state = PS_IDLE; n_lp = 1'b0; n_wake = 1'b0;
               end
            end else if (prior_q && (wake_req || force_exit)) begin
               n_wake = 1'b1;
            end
         end
         default: n_state = PS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PS_IDLE; pend_q <= 1'b0; lp_q <= 1'b0;
         exiting_q <= 1'b0; wake_q <= 1'b0; prior_q <= 1'b0;
         enter_q <= 1'b0; exit_q <= 1'b0; wup_q <= 1'b0; ack_q <= 1'b0;
      end else begin
         state_q <= n_state; pend_q <= n_pend; lp_q <= n_lp;
         exiting_q <= n_exiting; wake_q <= n_wake; prior_q <= n_prior;
         enter_q <= n_enter; exit_q <= n_exit; wup_q <= n_wup; ack_q <= n_ack;
      end
   end

   assign state_o     = state_q;
   assign low_pwr_o   = lp_q;
   assign pdn_enter_o = enter_q;
   assign pdn_exit_o  = exit_q;
   assign wake_up_o   = wup_q;
   assign ref_ack_o   = ack_q;
   assign entry_run_o = pend_q;
   assign res_run_o   = is_low_pwr(state_q);
   assign exit_run_o  = exiting_q;

   // R4
   enter_lands_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      enter_q |-> is_low_pwr(state_q));

   // R7
   low_state_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_low_pwr(state_q) |-> lp_q);

   // R8
   ack_in_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_q |-> (state_q == PS_REF));

   // R9
   sref_via_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == PS_SREF) && ($past(state_q) != PS_SREF)) |-> ($past(state_q) == PS_REF));

   // R6
   exit_after_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exit_q |-> $past(res_zero));

   // R7
   wake_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wup_q |-> !lp_q);

   // R11
   pdn_act_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == PS_ACT_PDN) && !$past(wake_any)) |=> (state_q != PS_IDLE));
endmodule

// File: rtl/rank_pwr_ctrl.sv
`timescale 1ns/1ps
module rank_pwr_ctrl
   import rank_pwr_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 8,
   parameter int unsigned OPS_W     = 4,
   parameter int unsigned Q_W       = 5,
   parameter int unsigned ENTRY_DLY = 2,
   parameter int unsigned MIN_RES   = 5,
   parameter int unsigned EXIT_DLY  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act_evt,
   input  logic             pre_evt,
   input  logic [OPS_W-1:0] ops_pending,
   input  logic [Q_W-1:0]   rd_q_cnt,
   input  logic [Q_W-1:0]   wr_q_cnt,
   input  logic             bus_wr_next,
   input  logic             pdn_req,
   input  logic             wake_req,
   input  logic             ref_req,
   input  logic             ref_done,
   output logic [2:0]       pwr_state,
   output logic             low_pwr,
   output logic             pdn_enter,
   output logic             pdn_exit,
   output logic             wake_up,
   output logic             ref_ack
);
   generate
      if (NUM_BANKS < 1) begin : g_bad_banks
         $error("NUM_BANKS must be at least 1");
      end
      if ((OPS_W < 1) || (Q_W < 1)) begin : g_bad_width
         $error("OPS_W and Q_W must be at least 1");
      end
   endgenerate

   logic bank_en, bank_open_nxt;
   logic ops_idle, force_exit;
   logic entry_load, entry_run, entry_zero;
   logic res_load, res_run, res_zero;
   logic exit_load, exit_run, exit_zero;
   pwr_state_e state;

   assign ops_idle   = (ops_pending == '0);
   assign force_exit = (rd_q_cnt != '0) || (bus_wr_next && (wr_q_cnt != '0));

   rank_bank_tracker #(.NUM_BANKS(NUM_BANKS)) i_banks (
      .clk(clk), .rst_n(rst_n), .en(bank_en),
      .act_evt(act_evt), .pre_evt(pre_evt), .any_open_nxt(bank_open_nxt)
   );

   rank_down_counter #(.MAX(ENTRY_DLY)) i_entry_cnt (
      .clk(clk), .rst_n(rst_n), .load(entry_load), .run(entry_run), .zero(entry_zero)
   );

   rank_down_counter #(.MAX(MIN_RES)) i_res_cnt (
      .clk(clk), .rst_n(rst_n), .load(res_load), .run(res_run), .zero(res_zero)
   );

   rank_down_counter #(.MAX(EXIT_DLY)) i_exit_cnt (
      .clk(clk), .rst_n(rst_n), .load(exit_load), .run(exit_run), .zero(exit_zero)
   );

   rank_pwr_fsm i_fsm (
      .clk(clk), .rst_n(rst_n),
      .act_evt(act_evt), .pre_evt(pre_evt), .bank_open_nxt(bank_open_nxt),
      .ops_idle(ops_idle), .pdn_req(pdn_req), .wake_req(wake_req),
      .ref_req(ref_req), .ref_done(ref_done), .force_exit(force_exit),
      .entry_zero(entry_zero), .res_zero(res_zero), .exit_zero(exit_zero),
      .state_o(state), .low_pwr_o(low_pwr), .pdn_enter_o(pdn_enter),
      .pdn_exit_o(pdn_exit), .wake_up_o(wake_up), .ref_ack_o(ref_ack),
      .bank_en_o(bank_en), .entry_load_o(entry_load), .entry_run_o(entry_run),
      .res_load_o(res_load), .res_run_o(res_run),
      .exit_load_o(exit_load), .exit_run_o(exit_run)
   );

   assign pwr_state = state;

   // R10
   forced_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == PS_SREF) && force_exit && res_zero && !ref_req) |=> pdn_exit);
endmodule

// File: tb/test_rank_pwr_ctrl.sv
`timescale 1ns/1ps
module test_rank_pwr_ctrl;
   localparam int ENTRY_DLY = 2;
   localparam int MIN_RES   = 5;
   localparam int EXIT_DLY  = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic act_evt = 0, pre_evt = 0, bus_wr_next = 0;
   logic pdn_req = 0, wake_req = 0, ref_req = 0, ref_done = 0;
   logic [3:0] ops_pending = '0;
   logic [4:0] rd_q_cnt = '0, wr_q_cnt = '0;
   logic [2:0] pwr_state;
   logic low_pwr, pdn_enter, pdn_exit, wake_up, ref_ack;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   rank_pwr_ctrl #(.ENTRY_DLY(ENTRY_DLY), .MIN_RES(MIN_RES), .EXIT_DLY(EXIT_DLY)) i_rank_pwr_ctrl (
      .clk(clk), .rst_n(rst_n), .act_evt(act_evt), .pre_evt(pre_evt),
      .ops_pending(ops_pending), .rd_q_cnt(rd_q_cnt), .wr_q_cnt(wr_q_cnt),
      .bus_wr_next(bus_wr_next), .pdn_req(pdn_req), .wake_req(wake_req),
      .ref_req(ref_req), .ref_done(ref_done), .pwr_state(pwr_state),
      .low_pwr(low_pwr), .pdn_enter(pdn_enter), .pdn_exit(pdn_exit),
      .wake_up(wake_up), .ref_ack(ref_ack)
   );

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic steps(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic count_to_exit(output int n);
      n = 0;
      do begin step(); n++; end while (!pdn_exit && n < 50);
   endtask

   task automatic count_to_wake(output int n);
      n = 0;
      do begin step(); n++; end while (!wake_up && n < 50);
   endtask

   task automatic enter_pre_pdn();
      pdn_req = 1; step(); pdn_req = 0;
      steps(ENTRY_DLY + 1);
      chk("R4 precharge power-down reached", pwr_state, 3);
   endtask

   task automatic wake_out();
      int n;
      wake_req = 1; count_to_exit(n); wake_req = 0;
      count_to_wake(n);
   endtask

   task automatic t_reset();
      chk("R1 reset state", pwr_state, 0);
      chk("R1 reset low_pwr", low_pwr, 0);
      chk("R1 reset strobes", {pdn_enter, pdn_exit, wake_up, ref_ack}, 0);
   endtask

   task automatic t_banks();
      pre_evt = 1; step(); pre_evt = 0;
      act_evt = 1; step(); act_evt = 0;
      chk("R2 first open gives active", pwr_state, 1);
      pre_evt = 1; step(); pre_evt = 0;
      chk("R2 close from zero saturates, back idle", pwr_state, 0);
      act_evt = 1; steps(3); act_evt = 0;
      pre_evt = 1; steps(2);
      chk("R2 two of three closed stays active", pwr_state, 1);
      step(); pre_evt = 0;
      chk("R2 all closed gives idle", pwr_state, 0);
   endtask

   task automatic t_pdn_pre();
      int n;
      pdn_req = 1; step(); pdn_req = 0;
      chk("R3 low_pwr after accept", low_pwr, 1);
      chk("R3 state unchanged while pending", pwr_state, 0);
      steps(ENTRY_DLY);
      chk("R4 not entered early", pwr_state, 0);
      step();
      chk("R4 entry to precharge power-down", pwr_state, 3);
      chk("R4 entry strobe", pdn_enter, 1);
      wake_req = 1; step(); wake_req = 0;
      count_to_exit(n);
      chk("R6 residency before exit", n, MIN_RES);
      chk("R7 exit to idle", pwr_state, 0);
      chk("R7 low_pwr held during exit delay", low_pwr, 1);
      count_to_wake(n);
      chk("R7 exit delay", n, EXIT_DLY + 1);
      chk("R7 low_pwr falls with wake_up", low_pwr, 0);
      step();
      chk("R7 wake_up is one cycle", wake_up, 0);
   endtask

   task automatic t_pdn_act();
      int n;
      act_evt = 1; step(); act_evt = 0;
      ops_pending = 3; pdn_req = 1; step(); pdn_req = 0;
      chk("R3 request ignored with ops pending", low_pwr, 0);
      steps(ENTRY_DLY + 1);
      chk("R3 stays active", pwr_state, 1);
      ops_pending = 0; pdn_req = 1; step(); pdn_req = 0;
      steps(ENTRY_DLY + 1);
      chk("R4 active enters active power-down", pwr_state, 2);
      act_evt = 1; step(); act_evt = 0;
      chk("R11 open ignored in power-down", pwr_state, 2);
      steps(MIN_RES + 1);
      wake_req = 1; step(); wake_req = 0;
      chk("R7 active power-down exits to active", pwr_state, 1);
      chk("R7 exit strobe", pdn_exit, 1);
      pre_evt = 1; step(); pre_evt = 0;
      count_to_wake(n);
      chk("R11 close ignored during exit delay", pwr_state, 1);
      pre_evt = 1; step(); pre_evt = 0;
      chk("R11 single bank still counted, idle after close", pwr_state, 0);
   endtask

   task automatic t_override();
      pdn_req = 1; step(); pdn_req = 0;
      wake_req = 1; step(); wake_req = 0;
      chk("R5 wake cancels pending entry", low_pwr, 0);
      steps(4);
      chk("R5 no entry after cancel", pwr_state, 0);
      pdn_req = 1; steps(2); pdn_req = 0;
      steps(2);
      chk("R5 repeated request restarts delay", pwr_state, 0);
      step();
      chk("R5 entry after restarted delay", pwr_state, 3);
      wake_out();
      pdn_req = 1; step(); pdn_req = 0;
      act_evt = 1; step(); act_evt = 0;
      chk("R5 bank event cancels entry", low_pwr, 0);
      steps(4);
      chk("R5 active, no power-down", pwr_state, 1);
      pre_evt = 1; step(); pre_evt = 0;
      pdn_req = 1; step(); pdn_req = 0;
      ops_pending = 1; steps(ENTRY_DLY + 1);
      chk("R4 ops at deadline drops entry", pwr_state, 0);
      chk("R4 low_pwr dropped", low_pwr, 0);
      ops_pending = 0;
   endtask

   task automatic t_refresh();
      ref_req = 1; pdn_req = 1; step(); ref_req = 0; pdn_req = 0;
      chk("R8 refresh wins over power-down", pwr_state, 4);
      chk("R8 ack strobe", ref_ack, 1);
      chk("R8 low_pwr clear in refresh from idle", low_pwr, 0);
      step();
      chk("R8 ack one cycle", ref_ack, 0);
      ref_done = 1; step(); ref_done = 0;
      chk("R9 refresh from idle returns idle", pwr_state, 0);
      act_evt = 1; step(); act_evt = 0;
      ref_req = 1; step(); ref_req = 0;
      chk("R8 refresh ignored in active", pwr_state, 1);
      chk("R8 no ack in active", ref_ack, 0);
      pre_evt = 1; step(); pre_evt = 0;
   endtask

   task automatic t_sref();
      int n;
      enter_pre_pdn();
      ref_req = 1; step(); ref_req = 0;
      chk("R8 refresh from precharge power-down", pwr_state, 4);
      chk("R8 low_pwr kept", low_pwr, 1);
      ref_done = 1; step(); ref_done = 0;
      chk("R9 enters self-refresh", pwr_state, 5);
      chk("R9 entry strobe", pdn_enter, 1);
      wr_q_cnt = 3; bus_wr_next = 0; steps(MIN_RES + 3);
      chk("R10 writes with read bus keep self-refresh", pwr_state, 5);
      bus_wr_next = 1; step();
      chk("R10 writes with write bus force exit", pwr_state, 0);
      chk("R10 exit strobe", pdn_exit, 1);
      count_to_wake(n);
      chk("R10 awake after forced exit", low_pwr, 0);
      wr_q_cnt = 0; bus_wr_next = 0;
      enter_pre_pdn();
      ref_req = 1; step(); ref_req = 0;
      ops_pending = 2; ref_done = 1; step(); ref_done = 0; ops_pending = 0;
      chk("R9 ops pending returns idle", pwr_state, 0);
      chk("R9 low_pwr cleared", low_pwr, 0);
      enter_pre_pdn();
      ref_req = 1; step(); ref_req = 0;
      ref_done = 1; step(); ref_done = 0;
      ref_req = 1; step(); ref_req = 0;
      chk("R8 refresh ignored in self-refresh", pwr_state, 5);
      chk("R8 no ack in self-refresh", ref_ack, 0);
      rd_q_cnt = 1; count_to_exit(n); rd_q_cnt = 0;
      chk("R10 queued read forces exit after residency", n, MIN_RES);
      chk("R10 exit to idle", pwr_state, 0);
      count_to_wake(n);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      step();
      t_reset();
      t_banks();
      t_pdn_pre();
      t_pdn_act();
      t_override();
      t_refresh();
      t_sref();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule